// File: doc/BRIEF.md
# Conditional Branch Resolver

This unit settles, for a single 32-bit instruction word, whether control flow leaves the sequential path and where it goes. It handles four branch forms: an unconditional jump with a 24-bit word displacement, a conditional jump with a 14-bit word displacement, and two conditional jumps whose destination is taken from the link register or from the count register. The conditional forms share a 4-bit option field. That field can ask for the count register to be decremented, for the decremented count to be compared with zero, and for one selected bit of the condition register to be compared with a wanted polarity.

The resolution is combinational, from the instruction word, the current PC, the condition register and the held count and link values. The unit owns the count and link registers. They are updated on the clock edge that ends the instruction's cycle, and each cycle carries at most one instruction. The surrounding pipeline loads either register through a dedicated load port, which has priority over a branch write in the same cycle. The unit flags words it cannot resolve as illegal, and such words leave no trace.

Top module: `branch_resolver`

## Requirements
- R1: A synchronous reset clears both the count register (`ctrValue`) and the link register (`lnkValue`) to zero.
- R2: For the conditional forms, the option code is word bits [25:22]. The legal codes behave as follows. 1010 is always taken. 0010 is taken when the condition bit is 0, and 0110 when it is 1. 1000 decrements the count and is taken when the result is non-zero; 1001 does the same but is taken when the result is zero. 0000 and 0100 decrement the count and are taken when the result is non-zero and the condition bit is 0 or 1 respectively. 0001 and 0101 decrement the count and are taken when the result is zero and the condition bit is 0 or 1 respectively.
- R3: The condition bit index is word bits [20:16]. Index 0 selects `condReg[31]` and index 31 selects `condReg[0]`.
- R4: Word bit 21, the prediction hint, has no effect on any output.
- R5: The conditional displacement form has primary opcode 16 in bits [31:26]. Its displacement is bits [15:2] followed by two zero bits, sign-extended from bit 15. When taken, the next PC is PC+displacement if word bit 1 is 0, and the displacement itself if bit 1 is 1.
- R6: The unconditional form has primary opcode 18. It is always taken and its option field is not decoded. Its displacement is bits [25:2] followed by two zero bits, sign-extended from bit 25. Word bit 1 selects an absolute or PC-relative target, as in R5.
- R7: Primary opcode 19 with bits [10:1] equal to 16 targets the link register, and with bits [10:1] equal to 528 targets the count register. When taken, the next PC is the register's value before this instruction, with bits [1:0] cleared.
- R8: A decrementing option code tests the count value minus one, modulo 2^32. In that cycle `ctrWe` is 1 and `ctrNew` equals that value, and `ctrValue` holds it after the clock edge. Otherwise the count register holds its value.
- R9: When word bit 0 is set on a legal branch, `lnkWe` is 1 and `lnkNew` is PC+4, whether or not the branch is taken. `lnkValue` holds PC+4 after the edge.
- R10: The following set `illegal`: a conditional option code not listed in R2, a count-register-target branch with a decrementing option code, and a word that is none of the four forms. An illegal word is not taken, gives PC+4 as the next PC, and writes neither register.
- R11: When no branch is taken, including when `instrValid` is 0, `nextPc` is PC+4.
- R12: `ctrLoadEn` loads `ctrLoadVal`, and `lnkLoadEn` loads `lnkLoadVal`, on the next edge. A load has priority over a branch write to the same register in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | An instruction is present this cycle |
| instrWord | input | 32 | Instruction word |
| curPc | input | 32 | Address of the instruction |
| condReg | input | 32 | Condition register, bit 0 at the MSB end |
| ctrLoadEn | input | 1 | Load the count register |
| ctrLoadVal | input | 32 | Value for a count load |
| lnkLoadEn | input | 1 | Load the link register |
| lnkLoadVal | input | 32 | Value for a link load |
| taken | output | 1 | Branch is taken |
| nextPc | output | 32 | Address of the next instruction |
| illegal | output | 1 | Word is an unsupported or invalid branch form |
| ctrWe | output | 1 | Branch writes the count register |
| ctrNew | output | 32 | Decremented count value |
| lnkWe | output | 1 | Branch writes the link register |
| lnkNew | output | 32 | Return address (PC+4) |
| ctrValue | output | 32 | Current count register |
| lnkValue | output | 32 | Current link register |

## Verification
The alignment property assumes `curPc` is a multiple of four. The bench only drives word-aligned PCs, so every taken target must have its two low bits clear. The register-update properties assume that a load and a branch write may coincide, and that the load then wins. The bench draws those two events independently, so every combination occurs. The random words are spread across the four forms and some junk words. The option codes are mostly legal, with occasional reserved codes. The count register is reloaded often with values from 0 to 3, so the zero and wrap-around outcomes of the decrement test are reached regularly.

// File: rtl/branch_resolver_pkg.sv
package branch_resolver_pkg;
  localparam int XLEN     = 32;
  localparam int IDX_W    = $clog2(XLEN);
  localparam int OPC_W    = 6;
  localparam int OPT_W    = 4;
  localparam int XO_W     = 10;
  localparam int LONG_W   = 24;
  localparam int SHORT_W  = 14;

  localparam logic [OPC_W-1:0] OPC_UNCOND = 6'd18;
  localparam logic [OPC_W-1:0] OPC_COND   = 6'd16;
  localparam logic [OPC_W-1:0] OPC_REGTGT = 6'd19;
  localparam logic [XO_W-1:0]  XO_LINK    = 10'd16;
  localparam logic [XO_W-1:0]  XO_COUNT   = 10'd528;

  typedef enum logic [2:0] {
    TGT_SEQ,
    TGT_REL,
    TGT_ABS,
    TGT_LNK,
    TGT_CTR
  } tgtSel_e;

  typedef struct packed {
    logic    taken;
    logic    illegal;
    logic    decEn;
    logic    linkEn;
    logic    shortDisp;
    tgtSel_e tgtSel;
  } brStrobe_t;
endpackage

// File: rtl/branch_resolver_ctrl.sv
module branch_resolver_ctrl
  import branch_resolver_pkg::*;
(
  input  logic            instrValid,
  input  logic [31:0]     instrWord,
  input  logic [XLEN-1:0] condReg,
  input  logic            ctrDecZero,
  output brStrobe_t       strobe
);
  logic [OPC_W-1:0] opcd;
  logic [OPT_W-1:0] opt;
  logic [IDX_W-1:0] bitSel;
  logic [IDX_W-1:0] bitIdx;
  logic [XO_W-1:0]  xo;
  logic             absSel;
  logic             linkReq;
  logic             unusedBits;

  assign opcd       = instrWord[31:26];
  assign opt        = instrWord[25:22];
  assign bitSel     = instrWord[20:16];
  assign xo         = instrWord[10:1];
  assign absSel     = instrWord[1];
  assign linkReq    = instrWord[0];
  assign unusedBits = ^{instrWord[21], instrWord[15:11]};

  logic isUncond, isCond, isLnk, isCtr, anyBranch;
  assign isUncond  = (opcd == OPC_UNCOND);
  assign isCond    = (opcd == OPC_COND);
  assign isLnk     = (opcd == OPC_REGTGT) && (xo == XO_LINK);
  assign isCtr     = (opcd == OPC_REGTGT) && (xo == XO_COUNT);
  assign anyBranch = isUncond | isCond | isLnk | isCtr;

  // option decode: bit1 low = decrement/test count, bit0 = want zero,
  // bit3 low = test condition bit, bit2 = wanted polarity
  logic optLegal;
  always_comb begin
    unique case (opt)
      4'b0000, 4'b0001, 4'b0010,
      4'b0100, 4'b0101, 4'b0110,
      4'b1000, 4'b1001, 4'b1010: optLegal = 1'b1;
      default:                   optLegal = 1'b0;
    endcase
  end

  logic needDec, testCond, wantSet, wantZero;
  assign needDec  = ~opt[1];
  assign testCond = ~opt[3];
  assign wantSet  = opt[2];
  assign wantZero = opt[0];

  logic condBit, condOk, ctrOk;
  assign bitIdx  = IDX_W'(XLEN - 1) - bitSel;
  assign condBit = condReg[bitIdx];
  assign condOk  = ~testCond | (condBit == wantSet);
  assign ctrOk   = ~needDec  | (ctrDecZero == wantZero);

  logic badForm, goodInstr, takeIt;
  assign badForm   = ~anyBranch | (~isUncond & ~optLegal) | (isCtr & needDec);
  assign goodInstr = instrValid & ~badForm;
  assign takeIt    = goodInstr & (isUncond | (condOk & ctrOk));

  always_comb begin
    strobe           = '0;
    strobe.taken     = takeIt;
    strobe.illegal   = instrValid & badForm;
    strobe.decEn     = goodInstr & ~isUncond & needDec;
    strobe.linkEn    = goodInstr & linkReq;
    strobe.shortDisp = isCond;
    if (!takeIt)     strobe.tgtSel = TGT_SEQ;
    else if (isLnk)  strobe.tgtSel = TGT_LNK;
    else if (isCtr)  strobe.tgtSel = TGT_CTR;
    else if (absSel) strobe.tgtSel = TGT_ABS;
    else             strobe.tgtSel = TGT_REL;
  end
endmodule

// File: rtl/branch_resolver_dp.sv
module branch_resolver_dp
  import branch_resolver_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   curPc,
  input  logic [LONG_W-1:0] dispField,
  input  brStrobe_t         strobe,
  input  logic              ctrLoadEn,
  input  logic [XLEN-1:0]   ctrLoadVal,
  input  logic              lnkLoadEn,
  input  logic [XLEN-1:0]   lnkLoadVal,
  output logic              ctrDecZero,
  output logic [XLEN-1:0]   nextPc,
  output logic [XLEN-1:0]   ctrNew,
  output logic [XLEN-1:0]   lnkNew,
  output logic [XLEN-1:0]   ctrValue,
  output logic [XLEN-1:0]   lnkValue
);
  logic [XLEN-1:0] ctrReg, lnkReg;
  logic [XLEN-1:0] pcSeq, ctrDec;
  logic [XLEN-1:0] dispShort, dispLong, disp;
  logic            unusedStrobe;

  assign unusedStrobe = strobe.taken ^ strobe.illegal;

  assign pcSeq      = curPc + XLEN'(4);
  assign ctrDec     = ctrReg - XLEN'(1);
  assign ctrDecZero = (ctrDec == '0);

  assign dispShort = {{(XLEN-SHORT_W-2){dispField[SHORT_W-1]}},
                      dispField[SHORT_W-1:0], 2'b00};
  assign dispLong  = {{(XLEN-LONG_W-2){dispField[LONG_W-1]}},
                      dispField, 2'b00};
  assign disp      = strobe.shortDisp ? dispShort : dispLong;

  always_comb begin
    unique case (strobe.tgtSel)
      TGT_REL: nextPc = curPc + disp;
      TGT_ABS: nextPc = disp;
      TGT_LNK: nextPc = {lnkReg[XLEN-1:2], 2'b00};
      TGT_CTR: nextPc = {ctrReg[XLEN-1:2], 2'b00};
      default: nextPc = pcSeq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                ctrReg <= '0;
    else if (ctrLoadEn)     ctrReg <= ctrLoadVal;
    else if (strobe.decEn)  ctrReg <= ctrDec;
  end

  always_ff @(posedge clk) begin
    if (rst)                lnkReg <= '0;
    else if (lnkLoadEn)     lnkReg <= lnkLoadVal;
    else if (strobe.linkEn) lnkReg <= pcSeq;
  end

  assign ctrNew   = ctrDec;
  assign lnkNew   = pcSeq;
  assign ctrValue = ctrReg;
  assign lnkValue = lnkReg;
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import branch_resolver_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            instrValid,
  input  logic [31:0]     instrWord,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] condReg,
  input  logic            ctrLoadEn,
  input  logic [XLEN-1:0] ctrLoadVal,
  input  logic            lnkLoadEn,
  input  logic [XLEN-1:0] lnkLoadVal,
  output logic            taken,
  output logic [XLEN-1:0] nextPc,
  output logic            illegal,
  output logic            ctrWe,
  output logic [XLEN-1:0] ctrNew,
  output logic            lnkWe,
  output logic [XLEN-1:0] lnkNew,
  output logic [XLEN-1:0] ctrValue,
  output logic [XLEN-1:0] lnkValue
);
  brStrobe_t strobe;
  logic      ctrDecZero;

  branch_resolver_ctrl u_ctrl (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .condReg    (condReg),
    .ctrDecZero (ctrDecZero),
    .strobe     (strobe)
  );

  branch_resolver_dp u_dp (
    .clk        (clk),
    .rst        (rst),
    .curPc      (curPc),
    .dispField  (instrWord[25:2]),
    .strobe     (strobe),
    .ctrLoadEn  (ctrLoadEn),
    .ctrLoadVal (ctrLoadVal),
    .lnkLoadEn  (lnkLoadEn),
    .lnkLoadVal (lnkLoadVal),
    .ctrDecZero (ctrDecZero),
    .nextPc     (nextPc),
    .ctrNew     (ctrNew),
    .lnkNew     (lnkNew),
    .ctrValue   (ctrValue),
    .lnkValue   (lnkValue)
  );

  assign taken   = strobe.taken;
  assign illegal = strobe.illegal;
  assign ctrWe   = strobe.decEn;
  assign lnkWe   = strobe.linkEn;
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] curPc,
  input logic        ctrLoadEn,
  input logic [31:0] ctrLoadVal,
  input logic        lnkLoadEn,
  input logic        taken,
  input logic [31:0] nextPc,
  input logic        illegal,
  input logic        ctrWe,
  input logic [31:0] ctrNew,
  input logic        lnkWe,
  input logic [31:0] ctrValue,
  input logic [31:0] lnkValue
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ctrValue == 32'd0) && (lnkValue == 32'd0));

  a_r8_dec_written: assert property (@(posedge clk) disable iff (rst)
    ctrWe && !ctrLoadEn |=> ctrValue == $past(ctrValue) - 32'd1);

  a_r8_dec_value: assert property (@(posedge clk) disable iff (rst)
    ctrWe |-> ctrNew == ctrValue - 32'd1);

  a_r8_ctr_holds: assert property (@(posedge clk) disable iff (rst)
    !ctrWe && !ctrLoadEn |=> $stable(ctrValue));

  a_r12_ctr_load: assert property (@(posedge clk) disable iff (rst)
    ctrLoadEn |=> ctrValue == $past(ctrLoadVal));

  a_r9_link_written: assert property (@(posedge clk) disable iff (rst)
    lnkWe && !lnkLoadEn |=> lnkValue == $past(curPc) + 32'd4);

  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !taken && !ctrWe && !lnkWe && (nextPc == curPc + 32'd4));

  a_r11_sequential: assert property (@(posedge clk) disable iff (rst)
    !taken |-> nextPc == curPc + 32'd4);

  a_r7_target_aligned: assert property (@(posedge clk) disable iff (rst)
    taken && (curPc[1:0] == 2'b00) |-> nextPc[1:0] == 2'b00);
endmodule

bind branch_resolver branch_resolver_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .curPc      (curPc),
  .ctrLoadEn  (ctrLoadEn),
  .ctrLoadVal (ctrLoadVal),
  .lnkLoadEn  (lnkLoadEn),
  .taken      (taken),
  .nextPc     (nextPc),
  .illegal    (illegal),
  .ctrWe      (ctrWe),
  .ctrNew     (ctrNew),
  .lnkWe      (lnkWe),
  .ctrValue   (ctrValue),
  .lnkValue   (lnkValue)
);

// File: tb/tb_branch_resolver.sv
`timescale 1ns/1ps
module tb_branch_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0, curPc = '0, condReg = '0;
  logic        ctrLoadEn = 1'b0, lnkLoadEn = 1'b0;
  logic [31:0] ctrLoadVal = '0, lnkLoadVal = '0;
  logic        taken, illegal, ctrWe, lnkWe;
  logic [31:0] nextPc, ctrNew, lnkNew, ctrValue, lnkValue;

  int checks = 0;
  int errors = 0;
  logic [31:0] mCtr = '0, mLnk = '0;

  always #2 clk = ~clk;

  branch_resolver dut (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .curPc(curPc), .condReg(condReg), .ctrLoadEn(ctrLoadEn),
    .ctrLoadVal(ctrLoadVal), .lnkLoadEn(lnkLoadEn), .lnkLoadVal(lnkLoadVal),
    .taken(taken), .nextPc(nextPc), .illegal(illegal), .ctrWe(ctrWe),
    .ctrNew(ctrNew), .lnkWe(lnkWe), .lnkNew(lnkNew),
    .ctrValue(ctrValue), .lnkValue(lnkValue)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCond(input logic [5:0] opc, input logic [3:0] opt,
      input logic hint, input logic [4:0] bi, input logic [15:0] low);
    return {opc, opt, hint, bi, low};
  endfunction

  function automatic logic [31:0] mkBc(input logic [3:0] opt, input logic hint,
      input logic [4:0] bi, input logic [15:0] disp, input logic aa, input logic lk);
    return mkCond(6'd16, opt, hint, bi, {disp[15:2], aa, lk});
  endfunction

  function automatic logic [31:0] mkReg(input logic [3:0] opt, input logic hint,
      input logic [4:0] bi, input logic toCtr, input logic lk);
    return mkCond(6'd19, opt, hint, bi, {5'd0, toCtr ? 10'd528 : 10'd16, lk});
  endfunction

  function automatic logic [31:0] mkJmp(input logic [23:0] li, input logic aa, input logic lk);
    return {6'd18, li, aa, lk};
  endfunction

  task automatic model(input logic [31:0] w, pc, cr, ctr, lnk,
      output logic tk, output logic [31:0] np, output logic il,
      output logic cwe, output logic lwe);
    logic [31:0] dec, tgt, dsp;
    logic cb, legal, dodec, cnd, fU, fB, fL, fC;
    dec = ctr - 32'd1;
    cb  = cr[5'd31 - w[20:16]];
    fU = (w[31:26] == 6'd18);
    fB = (w[31:26] == 6'd16);
    fL = (w[31:26] == 6'd19) && (w[10:1] == 10'd16);
    fC = (w[31:26] == 6'd19) && (w[10:1] == 10'd528);
    legal = 1'b1; dodec = 1'b0; cnd = 1'b0;
    case (w[25:22])
      4'd0:  begin dodec = 1; cnd = (dec != 0) && !cb; end
      4'd1:  begin dodec = 1; cnd = (dec == 0) && !cb; end
      4'd2:  cnd = !cb;
      4'd4:  begin dodec = 1; cnd = (dec != 0) && cb; end
      4'd5:  begin dodec = 1; cnd = (dec == 0) && cb; end
      4'd6:  cnd = cb;
      4'd8:  begin dodec = 1; cnd = (dec != 0); end
      4'd9:  begin dodec = 1; cnd = (dec == 0); end
      4'd10: cnd = 1;
      default: legal = 1'b0;
    endcase
    if (fU) begin
      il = 0; tk = 1;
      dsp = {{6{w[25]}}, w[25:2], 2'b00};
      tgt = w[1] ? dsp : pc + dsp;
    end else if (fB || fL || fC) begin
      il = !legal || (fC && dodec);
      tk = !il && cnd;
      dsp = {{16{w[15]}}, w[15:2], 2'b00};
      if (fL)      tgt = {lnk[31:2], 2'b00};
      else if (fC) tgt = {ctr[31:2], 2'b00};
      else         tgt = w[1] ? dsp : pc + dsp;
    end else begin
      il = 1; tk = 0; tgt = 0;
    end
    np  = tk ? tgt : pc + 32'd4;
    cwe = !il && !fU && dodec;
    lwe = !il && w[0];
  endtask

  task automatic step(input string tag, input logic [31:0] w, pc, cr,
      input logic cle, input logic [31:0] clv, input logic lle, input logic [31:0] llv);
    logic tk, il, cwe, lwe;
    logic [31:0] np;
    @(negedge clk);
    instrValid = 1'b1; instrWord = w; curPc = pc; condReg = cr;
    ctrLoadEn = cle; ctrLoadVal = clv; lnkLoadEn = lle; lnkLoadVal = llv;
    #1;
    model(w, pc, cr, mCtr, mLnk, tk, np, il, cwe, lwe);
    chk(tag, "ctrValue", ctrValue, mCtr);
    chk(tag, "lnkValue", lnkValue, mLnk);
    chk(tag, "taken", {31'd0, taken}, {31'd0, tk});
    chk(tag, "nextPc", nextPc, np);
    chk(tag, "illegal", {31'd0, illegal}, {31'd0, il});
    chk(tag, "ctrWe", {31'd0, ctrWe}, {31'd0, cwe});
    chk(tag, "lnkWe", {31'd0, lnkWe}, {31'd0, lwe});
    if (cwe) chk(tag, "ctrNew", ctrNew, mCtr - 32'd1);
    if (lwe) chk(tag, "lnkNew", lnkNew, pc + 32'd4);
    @(posedge clk);
    if (cle) mCtr = clv; else if (cwe) mCtr = mCtr - 32'd1;
    if (lle) mLnk = llv; else if (lwe) mLnk = pc + 32'd4;
  endtask

  task automatic idleCheck(input string tag, input logic [31:0] pc);
    @(negedge clk);
    instrValid = 1'b0; curPc = pc; ctrLoadEn = 0; lnkLoadEn = 0;
    #1;
    chk(tag, "ctrValue", ctrValue, mCtr);
    chk(tag, "lnkValue", lnkValue, mLnk);
    chk(tag, "idle taken", {31'd0, taken}, 32'd0);
    chk(tag, "idle nextPc", nextPc, pc + 32'd4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] legalOpts [9];
    legalOpts = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10};
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", "reset ctr", ctrValue, 32'd0);
    chk("R1", "reset lnk", lnkValue, 32'd0);
    idleCheck("R11", 32'h0000_2000);

    // R3: bit index 0 is the MSB, 31 is the LSB
    step("R3", mkBc(4'd6, 0, 5'd0, 16'h0040, 0, 0), 32'h100, 32'h8000_0000, 0, 0, 0, 0);
    step("R3", mkBc(4'd6, 0, 5'd31, 16'h0040, 0, 0), 32'h100, 32'h0000_0001, 0, 0, 0, 0);
    step("R3", mkBc(4'd6, 0, 5'd0, 16'h0040, 0, 0), 32'h100, 32'h0000_0001, 0, 0, 0, 0);
    // R4: hint bit flipped, same outcome
    step("R4", mkBc(4'd2, 0, 5'd2, 16'h0100, 0, 0), 32'h200, 32'h0, 0, 0, 0, 0);
    step("R4", mkBc(4'd2, 1, 5'd2, 16'h0100, 0, 0), 32'h200, 32'h0, 0, 0, 0, 0);
    // R5: negative relative and absolute short displacement
    step("R5", mkBc(4'd10, 0, 5'd0, 16'hFFF0, 0, 0), 32'h1000, 32'h0, 0, 0, 0, 0);
    step("R5", mkBc(4'd10, 0, 5'd0, 16'h8004, 1, 0), 32'h1000, 32'h0, 0, 0, 0, 0);
    // R6: long displacement, negative relative and absolute
    step("R6", mkJmp(24'hFFFFF0, 0, 0), 32'h0001_0000, 32'h0, 0, 0, 0, 0);
    step("R6", mkJmp(24'h800001, 1, 0), 32'h0001_0000, 32'h0, 0, 0, 0, 0);
    // R12 / R7: load registers, then branch through them
    step("R12", 32'h0, 32'h0, 32'h0, 1, 32'h0000_2002, 1, 32'h0000_1003);
    step("R7", mkReg(4'd10, 0, 5'd0, 0, 0), 32'h40, 32'h0, 0, 0, 0, 0);
    step("R7", mkReg(4'd10, 0, 5'd0, 1, 0), 32'h40, 32'h0, 0, 0, 0, 0);
    // R9: link-target branch with link uses the old value, then writes PC+4
    step("R9", mkReg(4'd10, 0, 5'd0, 0, 1), 32'h100, 32'h0, 0, 0, 0, 0);
    step("R9", mkBc(4'd2, 0, 5'd0, 16'h0020, 0, 1), 32'h300, 32'hFFFF_FFFF, 0, 0, 0, 0);
    // R8: decrement from 1 reaches zero; decrement from 0 wraps
    step("R8", 32'h0, 32'h0, 32'h0, 1, 32'd1, 0, 0);
    step("R8", mkBc(4'd9, 0, 5'd0, 16'h0010, 0, 0), 32'h500, 32'h0, 0, 0, 0, 0);
    step("R8", mkBc(4'd8, 0, 5'd0, 16'h0010, 0, 0), 32'h500, 32'h0, 0, 0, 0, 0);
    idleCheck("R8", 32'h600);
    // R12: load wins over a decrement in the same cycle
    step("R12", mkBc(4'd8, 0, 5'd0, 16'h0010, 0, 0), 32'h700, 32'h0, 1, 32'd5, 0, 0);
    idleCheck("R12", 32'h700);
    // R10: illegal forms
    step("R10", mkReg(4'd0, 0, 5'd0, 1, 1), 32'h800, 32'h0, 0, 0, 0, 0);
    step("R10", mkBc(4'd3, 0, 5'd0, 16'h0010, 0, 1), 32'h800, 32'h0, 0, 0, 0, 0);
    step("R10", 32'h7C00_0000, 32'h800, 32'h0, 0, 0, 0, 0);
    idleCheck("R10", 32'h800);
    // R11: not taken because the condition bit is set
    step("R11", mkBc(4'd2, 0, 5'd5, 16'h0010, 0, 0), 32'h900, 32'h0400_0000, 0, 0, 0, 0);

    // R2: constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w, pc, cr, r;
      logic [3:0]  opt;
      logic        cle, lle;
      int          form;
      form = $urandom % 5;
      r    = $urandom;
      opt  = (($urandom % 8) == 0) ? 4'($urandom) : legalOpts[$urandom % 9];
      case (form)
        0: w = mkJmp(24'($urandom), r[0], r[1]);
        1: w = mkBc(opt, r[2], 5'($urandom), 16'($urandom), r[0], r[1]);
        2: w = mkReg(opt, r[2], 5'($urandom), 0, r[1]);
        3: w = mkReg(opt, r[2], 5'($urandom), 1, r[1]);
        default: w = $urandom;
      endcase
      pc  = {$urandom % 32'h0100_0000, 2'b00} & 32'hFFFF_FFFC;
      cr  = $urandom;
      cle = (($urandom % 4) == 0);
      lle = (($urandom % 6) == 0);
      step("R2", w, pc, cr, cle, 32'($urandom % 4), lle, $urandom);
    end
    idleCheck("R8", 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule